// File: doc/BRIEF.md
# Matrix Recency Tracker for Page Frames

This block keeps the exact least-recently-used order of a set of N page frames. Each frame owns one row of an N-by-N bit matrix. When a frame is referenced, its row is filled with ones and then the column that belongs to it is wiped in every row. As a result, bit (i, j) is 1 exactly when frame i has been used more recently than frame j.

The frame to evict is the one whose row, read as an unsigned number, is the smallest. A replacement engine places a one-cycle reference strobe with the frame number on the inputs. It can read the current victim on `lruIdx` in every cycle. Loading the victim and any page table work stay outside the block.

Top module: `lru_matrix_tracker`

## Requirements
- R1: While `rstN` is low and after it is released, the matrix holds all zeros and `lruIdx` reports frame 0.
- R2: A valid reference to frame k fills row k with ones, except its own diagonal bit, which stays 0. In the next cycle `lruIdx` does not report k (N >= 2).
- R3: A valid reference to frame k clears bit k in every other row, so that column k holds only zeros afterwards.
- R4: `lruIdx` names the row with the smallest value. Bit j of row i holds the (i, j) cell, and column 0 is the least significant bit. When rows tie, the lowest frame number wins.
- R5: Frames that have never been referenced since reset are reported before any referenced frame, lowest number first.
- R6: The matrix update takes effect at the clock edge that samples the strobe, and `lruIdx` shows it from that edge on. Without a valid reference, `lruIdx` holds its value.
- R7: A reference whose index is N or larger (possible when N is not a power of two) is ignored and changes neither the matrix nor `lruIdx`.
- R8: `lruIdx` is always less than N.
- R9: For any reference string, `lruIdx` equals the head of an ideal recency list. That list starts as frames 0..N-1 and moves each referenced frame to its tail. This applies to N = 3 and N = 4.
- R10: Referencing frames 0 through N-1 in ascending order makes frame 0 the victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| refValid | input | 1 | Reference strobe, one cycle per reference |
| refIdx | input | $clog2(N) | Number of the referenced frame |
| lruIdx | output | $clog2(N) | Number of the least recently used frame |

## Verification
Two things can land in the same cycle: the victim readout and a reference to the very frame being reported as victim. A second case is two consecutive cycles that reference the same frame, where the row set and the column clear act on one row. The bench provokes the first case by feeding the current victim straight back as the next reference for several cycles. It provokes the second case with back-to-back strobes on one frame. A behavioural recency list judges every cycle. It demands that the reported frame move on in the cycle after the strobe and that a repeated reference leave the order unchanged.

// File: rtl/lru_pkg.sv
package lru_pkg;

  // Strobe bundle from the reference decoder to the recency matrix.
  typedef struct packed {
    logic touch;   // accepted in-range reference this cycle
  } lru_strobe_t;

endpackage

// File: rtl/lru_ctrl.sv
module lru_ctrl #(
  parameter  int N     = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                refValid,
  input  logic [IDX_W-1:0]    refIdx,
  output lru_pkg::lru_strobe_t strobe,
  output logic [N-1:0]        selVec
);

  localparam logic [IDX_W:0] FRAME_COUNT = (IDX_W+1)'(N);

  logic inRange;

  // An index at or above N maps to no frame and is dropped here.
  assign inRange = ({1'b0, refIdx} < FRAME_COUNT);

  for (genvar f = 0; f < N; f++) begin : g_dec
    assign selVec[f] = inRange && (refIdx == IDX_W'(f));
  end

  assign strobe.touch = refValid && inRange;

endmodule

// File: rtl/lru_matrix.sv
module lru_matrix #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  lru_pkg::lru_strobe_t strobe,
  input  logic [N-1:0]         selVec,
  output logic [N*N-1:0]       rowsFlat
);

  // rowsFlat[r*N + c] is cell (r, c); column 0 is bit 0 of each row.
  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      if (r == c) begin : g_diag
        // Set-then-clear always leaves the diagonal at zero: no storage.
        assign rowsFlat[r*N + c] = 1'b0;
      end else begin : g_cell
        logic cellQ;
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            cellQ <= 1'b0;
          end else if (strobe.touch) begin
            if (selVec[r]) begin
              cellQ <= 1'b1;          // row of the referenced frame
            end else if (selVec[c]) begin
              cellQ <= 1'b0;          // column of the referenced frame
            end
          end
        end
        assign rowsFlat[r*N + c] = cellQ;
      end
    end
  end

endmodule

// File: rtl/lru_min_pick.sv
module lru_min_pick #(
  parameter  int N     = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N*N-1:0]   rowsFlat,
  output logic [IDX_W-1:0] lruIdx
);

  logic [N-1:0] bestRow;

  // Linear scan; strict compare keeps the lowest index on ties.
  always_comb begin
    bestRow = rowsFlat[N-1:0];
    lruIdx  = '0;
    for (int i = 1; i < N; i++) begin
      if (rowsFlat[i*N +: N] < bestRow) begin
        bestRow = rowsFlat[i*N +: N];
        lruIdx  = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/lru_matrix_tracker.sv
module lru_matrix_tracker #(
  parameter  int N     = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refValid,
  input  logic [IDX_W-1:0] refIdx,
  output logic [IDX_W-1:0] lruIdx
);

  lru_pkg::lru_strobe_t strobe;
  logic [N-1:0]         selVec;
  logic [N*N-1:0]       matrixFlat;

  lru_ctrl #(.N(N)) ctrl_i (
    .refValid (refValid),
    .refIdx   (refIdx),
    .strobe   (strobe),
    .selVec   (selVec)
  );

  lru_matrix #(.N(N)) mat_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .selVec   (selVec),
    .rowsFlat (matrixFlat)
  );

  lru_min_pick #(.N(N)) pick_i (
    .rowsFlat (matrixFlat),
    .lruIdx   (lruIdx)
  );

endmodule

// File: rtl/lru_tracker_chk.sv
module lru_tracker_chk #(
  parameter  int N     = 4,
  localparam int IDX_W = $clog2(N)
) (
  input logic             clk,
  input logic             rstN,
  input logic             refValid,
  input logic [IDX_W-1:0] refIdx,
  input logic [IDX_W-1:0] lruIdx,
  input logic [N*N-1:0]   matrixFlat
);

  localparam logic [IDX_W:0] FRAME_COUNT = (IDX_W+1)'(N);

  logic             inRange;
  logic             seenRef;
  logic             lastValid;
  logic [IDX_W-1:0] lastIdx;
  logic             colBad;
  logic             rowBad;
  logic             minBad;
  logic [N-1:0]     lruRow;

  assign inRange = ({1'b0, refIdx} < FRAME_COUNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenRef   <= 1'b0;
      lastValid <= 1'b0;
      lastIdx   <= '0;
    end else begin
      lastValid <= refValid && inRange;
      lastIdx   <= refIdx;
      if (refValid && inRange) seenRef <= 1'b1;
    end
  end

  always_comb begin
    colBad = 1'b0;
    rowBad = 1'b0;
    minBad = 1'b0;
    lruRow = matrixFlat[int'(lruIdx)*N +: N];
    for (int i = 0; i < N; i++) begin
      if (i != int'(lastIdx)) begin
        if (matrixFlat[i*N + int'(lastIdx)])  colBad = 1'b1;
        if (!matrixFlat[int'(lastIdx)*N + i]) rowBad = 1'b1;
      end
      if (matrixFlat[i*N +: N] < lruRow) minBad = 1'b1;
      if (i < int'(lruIdx) && matrixFlat[i*N +: N] == lruRow) minBad = 1'b1;
    end
  end

  // R1 / R5: before any reference the victim is frame 0
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !seenRef |-> lruIdx == '0);

  a_r2_row_set: assert property (@(posedge clk) disable iff (!rstN)
    lastValid |-> !rowBad);

  a_r2_not_victim: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && inRange) |=> lruIdx != $past(refIdx));

  a_r3_col_clear: assert property (@(posedge clk) disable iff (!rstN)
    lastValid |-> !colBad);

  a_r4_min_row: assert property (@(posedge clk) disable iff (!rstN)
    !minBad);

  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !refValid |=> $stable(lruIdx));

  a_r7_out_range: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && !inRange) |=> $stable(lruIdx));

  a_r8_in_range: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, lruIdx} < FRAME_COUNT);

endmodule

bind lru_matrix_tracker lru_tracker_chk #(.N(N)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .refValid   (refValid),
  .refIdx     (refIdx),
  .lruIdx     (lruIdx),
  .matrixFlat (matrixFlat)
);

// File: tb/lru_matrix_tracker_tb_top.sv
`timescale 1ns/1ps
module lru_matrix_tracker_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rv4 = 1'b0;
  logic [1:0] ri4 = '0;
  logic [1:0] lru4;
  logic       rv3 = 1'b0;
  logic [1:0] ri3 = '0;
  logic [1:0] lru3;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  int  q4[$];
  int  q3[$];

  always #10 clk = ~clk;   // 50 MHz

  lru_matrix_tracker #(.N(4)) dut_i (
    .clk(clk), .rstN(rstN), .refValid(rv4), .refIdx(ri4), .lruIdx(lru4));

  lru_matrix_tracker #(.N(3)) dut3_i (
    .clk(clk), .rstN(rstN), .refValid(rv3), .refIdx(ri3), .lruIdx(lru3));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Ideal recency lists: head is least recent, tail most recent.
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q4 = {0, 1, 2, 3};
      q3 = {0, 1, 2};
    end else begin
      if (rv4) begin
        for (int p = 0; p < q4.size(); p++)
          if (q4[p] == int'(ri4)) begin q4.delete(p); break; end
        q4.push_back(int'(ri4));
      end
      if (rv3 && ri3 < 2'd3) begin   // R7: index 3 is ignored by the model
        for (int p = 0; p < q3.size(); p++)
          if (q3[p] == int'(ri3)) begin q3.delete(p); break; end
        q3.push_back(int'(ri3));
      end
    end
  end

  // Per-cycle comparison against the models (R9, R8).
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R9 N=4 order", int'(lru4), q4[0]);
      check("R9 N=3 order", int'(lru3), q3[0]);
      if (lru3 == 2'd3) check("R8 range", int'(lru3), 2);
    end
  end

  // Apply one cycle of stimulus; returns at the negedge after the edge.
  task automatic tick(input bit v4, input int i4, input bit v3, input int i3);
    rv4 = v4; ri4 = 2'(i4);
    rv3 = v3; ri3 = 2'(i3);
    @(negedge clk);
    rv4 = 1'b0; rv3 = 1'b0;
  endtask

  initial begin
    int prev;
    int vic;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset N=4", int'(lru4), 0);
    check("R1 reset N=3", int'(lru3), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(lru4), 0);

    // R5: untouched frames first, lowest number first
    tick(1, 0, 1, 0);
    check("R5 untouched next", int'(lru4), 1);
    check("R5 untouched next N=3", int'(lru3), 1);
    tick(1, 2, 1, 2);
    check("R5 skip referenced", int'(lru4), 1);
    tick(1, 1, 1, 1);
    check("R5 last untouched", int'(lru4), 3);
    check("R4 full N=3", int'(lru3), 0);
    tick(1, 3, 0, 0);
    check("R4 oldest referenced", int'(lru4), 0);

    // R6: idle cycles keep the victim
    prev = int'(lru4);
    repeat (5) tick(0, 0, 0, 0);
    check("R6 hold idle", int'(lru4), prev);

    // R2: feed the victim back as the next reference (same-cycle case)
    for (int n = 0; n < 8; n++) begin
      vic = int'(lru4);
      tick(1, vic, 1, int'(lru3));
      if (int'(lru4) == vic) check("R2 victim moved", int'(lru4), q4[0]);
      else check("R2 victim moved", 1, 1);
    end

    // R3: back-to-back references to one frame leave the order unchanged
    tick(1, 2, 1, 2);
    prev = int'(lru4);
    tick(1, 2, 1, 2);
    check("R3 repeat same frame", int'(lru4), prev);

    // R7: out-of-range index on the 3-frame tracker is ignored
    prev = int'(lru3);
    tick(0, 0, 1, 3);
    check("R7 ignored index", int'(lru3), prev);
    tick(0, 0, 1, 3);
    check("R7 ignored twice", int'(lru3), q3[0]);

    // R10: ascending sweep makes frame 0 the victim
    for (int f = 0; f < 4; f++) tick(1, f, 1, f % 3);
    check("R10 sweep N=4", int'(lru4), 0);
    check("R10 sweep N=3", int'(lru3), 1);

    // R9: 3-frame trace and a long random run on both trackers
    begin
      int trace[14] = '{0, 1, 2, 0, 2, 1, 1, 2, 0, 1, 2, 1, 0, 1};
      foreach (trace[t]) tick(1, trace[t], 1, trace[t]);
    end
    check("R9 trace N=3", int'(lru3), 2);
    for (int n = 0; n < 2000; n++)
      tick(($urandom_range(0, 3) != 0), $urandom_range(0, 3),
           ($urandom_range(0, 3) != 0), $urandom_range(0, 3));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule